// File: doc/BRIEF.md
# Nested PHY Register Access Engine

This engine reaches the PHY registers of a switch that are only visible through a second level of indirection. A client sends one request with an operation, a PHY number, a register number and data. The engine turns that request into a short series of accesses on a switch-register port. All of these accesses target one global device, which has a PHY command register and a PHY data register. The engine polls the PHY command register until the busy flag drops. It then returns read data together with a status code. A failed access, or a PHY that stays busy too long, ends the operation early and sets the status.

There are four operations. Read and write are the two basic ones. Read-modify-write reads a PHY register, clears the bits in a mask, sets the bits in a second mask and writes the result back. Powering up the serdes (PHY 0x0F, control register 0, clear bit 11) is one use of it. Page select writes a page number into the page register of a PHY: page 0 is copper and page 1 is serdes.

Both the request side and the response side use valid/ready handshakes. A request is taken only while `req_ready` is high, and the engine handles one operation at a time. A response stays presented, unchanged, until the client raises `rsp_ready`. On the switch side the engine keeps one access outstanding. Every field of an access holds while `sw_req_valid` waits for `sw_req_ready`. The engine waits for the response of an access before it issues the next one.

Top module: `phy_nest_acc`

## Requirements
- R1: Every switch-side access addresses device 0x1C, and only register 0x18 (PHY command) or register 0x19 (PHY data).
- R2: A command word is laid out as follows: bit 15 is busy and is set; bits 14:13 are zero; bit 12 is set; bits 11:10 hold the opcode (2 for read, 1 for write); bits 9:5 hold the PHY number; bits 4:0 hold the register number.
- R3: A read (`req_op` 0) performs three steps in order. It writes the read command, then reads register 0x18 until bit 15 is clear, then reads register 0x19. It then responds with status 0 and the data it read.
- R4: A write (`req_op` 1) performs three steps in order. It writes `req_wdata` to register 0x19, then writes the write command, then polls register 0x18 until bit 15 is clear. It then responds with status 0 and data 0.
- R5: Each poll phase issues at most 100 reads of the command register. If all 100 return busy, the engine responds with status 2 (timeout) and data 0. If the 100th read returns not-busy, the operation completes normally.
- R6: A switch-side response with its error flag set ends the operation at once. The engine makes no further access and responds with status 1 and data 0.
- R7: Read-modify-write (`req_op` 2) performs the read sequence of R3 and then the write sequence of R4. The value it writes is (old & ~`req_clr`) | `req_set`, and the response carries the old value. If the read phase fails, no write access is issued.
- R8: Page select (`req_op` 3) performs the write sequence of R4 on register 0x16 of `req_phy`, writing `req_wdata` as the page number. It ignores `req_reg`.
- R9: `req_ready` is high only while no operation is in progress. A response keeps `rsp_data` and `rsp_status` stable until `rsp_ready` is seen, and is withdrawn in the cycle after that.
- R10: While `sw_req_valid` is high and `sw_req_ready` is low, the switch-side request and all of its fields hold their values.
- R11: After reset, `req_ready` is 1, while `rsp_valid` and `sw_req_valid` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write, 3 page select |
| req_phy | input | 5 | PHY number |
| req_reg | input | 5 | PHY register number |
| req_wdata | input | 16 | Write data or page number |
| req_clr | input | 16 | Bits cleared by read-modify-write |
| req_set | input | 16 | Bits set by read-modify-write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed when high together with valid |
| rsp_data | output | 16 | Read data (old value for read-modify-write), 0 otherwise |
| rsp_status | output | 2 | 0 ok, 1 switch access error, 2 busy timeout |
| sw_req_valid | output | 1 | Switch access valid |
| sw_req_ready | input | 1 | Switch access accepted |
| sw_req_write | output | 1 | 1 write, 0 read |
| sw_req_dev | output | 5 | Device address |
| sw_req_reg | output | 5 | Register address |
| sw_req_wdata | output | 16 | Write data |
| sw_rsp_valid | input | 1 | Switch access response valid |
| sw_rsp_ready | output | 1 | Engine ready for the access response |
| sw_rsp_rdata | input | 16 | Read data of the access |
| sw_rsp_err | input | 1 | Access failed |

## Verification
Some rules are checked by assertions on every cycle. Requests must hold on both handshake ports while stalled. The poll counter must stay under its limit. An error response must lead straight to a client response, with no further access. Read data must reach the response one cycle after the data-register read. The order of accesses for each operation can only be shown by the bench's scenarios. The same holds for the exact number of polls at the limit, the merged value written back, the absence of writes after a failed read phase, and the page register address. These scenarios run against a bench-side model of the command and data registers, with a configurable number of busy replies and a configurable access that fails.

// File: rtl/phy_nest_pkg.sv
package phy_nest_pkg;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int BUSY_BIT = 15;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RMW   = 2'd2,
    OP_PAGE  = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_BUSERR  = 2'd1,
    ST_TIMEOUT = 2'd2
  } status_e;

  // Which access of the nested sequence is current
  typedef enum logic [1:0] {
    K_WDATA = 2'd0,
    K_WCMD  = 2'd1,
    K_POLL  = 2'd2,
    K_RDATA = 2'd3
  } step_e;

  function automatic logic [DW-1:0] mk_cmd(input logic rd, input logic [AW-1:0] phy,
                                           input logic [AW-1:0] rg);
    mk_cmd = {1'b1, 2'b00, 1'b1, (rd ? 2'b10 : 2'b01), phy, rg};
  endfunction
endpackage

// File: rtl/phy_poll_ctr.sv
module phy_poll_ctr #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign last = (cnt == CW'(LIMIT - 1));

  // R5
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));
endmodule

// File: rtl/phy_rmw_merge.sv
module phy_rmw_merge #(
  parameter int W = 16
) (
  input  logic [W-1:0] old_val,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_mask,
  output logic [W-1:0] new_val
);
  always_comb new_val = (old_val & ~clr_mask) | set_mask;
endmodule

// File: rtl/phy_access_mux.sv
module phy_access_mux
  import phy_nest_pkg::*;
#(
  parameter logic [AW-1:0] CMD_REG  = 5'h18,
  parameter logic [AW-1:0] DATA_REG = 5'h19
) (
  input  step_e          step,
  input  logic           cmd_rd,
  input  logic [AW-1:0]  phy,
  input  logic [AW-1:0]  rg,
  input  logic [DW-1:0]  wdat,
  output logic           acc_write,
  output logic [AW-1:0]  acc_reg,
  output logic [DW-1:0]  acc_wdata
);
  always_comb begin
    acc_write = 1'b0;
    acc_reg   = CMD_REG;
    acc_wdata = '0;
    unique case (step)
      K_WDATA: begin acc_write = 1'b1; acc_reg = DATA_REG; acc_wdata = wdat; end
      K_WCMD:  begin acc_write = 1'b1; acc_reg = CMD_REG;  acc_wdata = mk_cmd(cmd_rd, phy, rg); end
      K_POLL:  begin acc_write = 1'b0; acc_reg = CMD_REG; end
      K_RDATA: begin acc_write = 1'b0; acc_reg = DATA_REG; end
      default: ;
    endcase
  end
endmodule

// File: rtl/phy_nest_acc.sv
module phy_nest_acc
  import phy_nest_pkg::*;
#(
  parameter int            MAX_POLL = 100,
  parameter logic [AW-1:0] DEV_ADDR = 5'h1C,
  parameter logic [AW-1:0] CMD_REG  = 5'h18,
  parameter logic [AW-1:0] DATA_REG = 5'h19,
  parameter logic [AW-1:0] PAGE_REG = 5'h16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_phy,
  input  logic [AW-1:0] req_reg,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_clr,
  input  logic [DW-1:0] req_set,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [1:0]    rsp_status,
  output logic          sw_req_valid,
  input  logic          sw_req_ready,
  output logic          sw_req_write,
  output logic [AW-1:0] sw_req_dev,
  output logic [AW-1:0] sw_req_reg,
  output logic [DW-1:0] sw_req_wdata,
  input  logic          sw_rsp_valid,
  output logic          sw_rsp_ready,
  input  logic [DW-1:0] sw_rsp_rdata,
  input  logic          sw_rsp_err
);
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} state_e;

  state_e        state;
  step_e         step;
  logic          cmd_rd;
  op_e           op_q;
  logic [AW-1:0] phy_q, reg_q;
  logic [DW-1:0] wdat_q, clr_q, set_q, rd_q, merged;
  status_e       status_q;
  logic          poll_last, poll_clr, poll_inc, rsp_in, busy_seen;

  assign rsp_in    = (state == S_WAIT) && sw_rsp_valid;
  assign busy_seen = sw_rsp_rdata[BUSY_BIT];
  assign poll_clr  = rsp_in && !sw_rsp_err && (step == K_WCMD);
  assign poll_inc  = rsp_in && !sw_rsp_err && (step == K_POLL) && busy_seen && !poll_last;

  phy_poll_ctr #(.LIMIT(MAX_POLL)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(poll_clr), .inc(poll_inc), .last(poll_last)
  );

  phy_rmw_merge #(.W(DW)) u_merge (
    .old_val(sw_rsp_rdata), .clr_mask(clr_q), .set_mask(set_q), .new_val(merged)
  );

  phy_access_mux #(.CMD_REG(CMD_REG), .DATA_REG(DATA_REG)) u_mux (
    .step(step), .cmd_rd(cmd_rd), .phy(phy_q), .rg(reg_q), .wdat(wdat_q),
    .acc_write(sw_req_write), .acc_reg(sw_req_reg), .acc_wdata(sw_req_wdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      step     <= K_WCMD;
      cmd_rd   <= 1'b0;
      op_q     <= OP_READ;
      phy_q    <= '0;
      reg_q    <= '0;
      wdat_q   <= '0;
      clr_q    <= '0;
      set_q    <= '0;
      rd_q     <= '0;
      status_q <= ST_OK;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          op_q     <= op_e'(req_op);
          phy_q    <= req_phy;
          reg_q    <= (req_op == OP_PAGE) ? PAGE_REG : req_reg;
          wdat_q   <= req_wdata;
          clr_q    <= req_clr;
          set_q    <= req_set;
          rd_q     <= '0;
          status_q <= ST_OK;
          if (req_op == OP_READ || req_op == OP_RMW) begin
            cmd_rd <= 1'b1;
            step   <= K_WCMD;
          end else begin
            cmd_rd <= 1'b0;
            step   <= K_WDATA;
          end
          state <= S_ISSUE;
        end
        S_ISSUE: if (sw_req_ready) state <= S_WAIT;
        S_WAIT: if (sw_rsp_valid) begin
          if (sw_rsp_err) begin
            status_q <= ST_BUSERR;
            state    <= S_RESP;
          end else begin
            unique case (step)
              K_WDATA: begin step <= K_WCMD; state <= S_ISSUE; end
              K_WCMD:  begin step <= K_POLL; state <= S_ISSUE; end
              K_POLL: begin
                if (!busy_seen) begin
                  if (cmd_rd) begin step <= K_RDATA; state <= S_ISSUE; end
                  else state <= S_RESP;
                end else if (poll_last) begin
                  status_q <= ST_TIMEOUT;
                  state    <= S_RESP;
                end else begin
                  state <= S_ISSUE;
                end
              end
              K_RDATA: begin
                rd_q <= sw_rsp_rdata;
                if (op_q == OP_RMW) begin
                  wdat_q <= merged;
                  cmd_rd <= 1'b0;
                  step   <= K_WDATA;
                  state  <= S_ISSUE;
                end else begin
                  state <= S_RESP;
                end
              end
              default: state <= S_RESP;
            endcase
          end
        end
        S_RESP: if (rsp_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == S_IDLE);
  assign sw_req_valid = (state == S_ISSUE);
  assign sw_rsp_ready = (state == S_WAIT);
  assign sw_req_dev   = DEV_ADDR;
  assign rsp_valid    = (state == S_RESP);
  assign rsp_status   = status_q;
  assign rsp_data     = (status_q == ST_OK) ? rd_q : '0;

  // R10
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_req_valid && !sw_req_ready |=> sw_req_valid && $stable(sw_req_write)
      && $stable(sw_req_reg) && $stable(sw_req_wdata));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_status));

  // R6
  err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rsp_ready && sw_rsp_valid && sw_rsp_err |=> rsp_valid && !sw_req_valid
      && rsp_status == 2'd1);

  // R3
  rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rsp_ready && sw_rsp_valid && !sw_rsp_err && step == K_RDATA && op_q == OP_READ
      |=> rsp_valid && rsp_data == $past(sw_rsp_rdata));
endmodule

// File: tb/tb_phy_nest_acc.sv
`timescale 1ns/1ps
module tb_phy_nest_acc;
  localparam int MAXP = 100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [1:0]  req_op = '0;
  logic [4:0]  req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0, req_clr = '0, req_set = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [15:0] rsp_data;
  logic [1:0]  rsp_status;
  logic        sw_req_valid, sw_req_ready = 1'b0, sw_req_write;
  logic [4:0]  sw_req_dev, sw_req_reg;
  logic [15:0] sw_req_wdata;
  logic        sw_rsp_valid = 1'b0, sw_rsp_ready, sw_rsp_err = 1'b0;
  logic [15:0] sw_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  phy_nest_acc #(.MAX_POLL(MAXP)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_phy(req_phy),
    .req_reg(req_reg), .req_wdata(req_wdata), .req_clr(req_clr), .req_set(req_set),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_status(rsp_status),
    .sw_req_valid(sw_req_valid), .sw_req_ready(sw_req_ready), .sw_req_write(sw_req_write),
    .sw_req_dev(sw_req_dev), .sw_req_reg(sw_req_reg), .sw_req_wdata(sw_req_wdata),
    .sw_rsp_valid(sw_rsp_valid), .sw_rsp_ready(sw_rsp_ready), .sw_rsp_rdata(sw_rsp_rdata),
    .sw_rsp_err(sw_rsp_err)
  );

  int n_tests = 0, n_fail = 0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural stand-in for the switch global device and the PHYs
  logic [15:0] phy_mem [0:31][0:31];
  logic [15:0] e_cmd = '0, e_data = '0;
  int busy_left = 0, busy_cfg = 0, err_at = 0, n_acc = 0, cyc = 0;

  typedef struct packed {logic w; logic [4:0] rg; logic [15:0] d; logic chk;} acc_t;
  acc_t  exp_q[$];
  string tag_q[$];

  logic        s_rv = 0, s_rdy = 0, s_w = 0, s_rsp_rdy = 0, pend = 0, pend_e = 0;
  logic [4:0]  s_dev = '0, s_rg = '0;
  logic [15:0] s_wd = '0, pend_d = '0;

  function automatic logic [15:0] cmd_word(bit rd, int p, int r);
    cmd_word = 16'h9000 | (rd ? 16'h0800 : 16'h0400) | 16'((p & 31) << 5) | 16'(r & 31);
  endfunction

  task automatic accept();
    acc_t e;
    string t;
    n_acc++;
    check("R1", "device address", 32'(s_dev), 32'h1C);
    if (exp_q.size() == 0) begin
      n_tests++; n_fail++;
      $display("FAIL R6 unexpected access: actual reg 0x%0h expected none", s_rg);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, "access kind", {26'd0, s_w, s_rg}, {26'd0, e.w, e.rg});
      if (e.chk) check(t, "access data", 32'(s_wd), 32'(e.d));
    end
    pend_d = '0;
    pend_e = 1'b0;
    if (n_acc == err_at) begin
      pend_e = 1'b1;
      exp_q.delete();
      tag_q.delete();
    end else if (s_w && s_rg == 5'h19) begin
      e_data = s_wd;
    end else if (s_w && s_rg == 5'h18) begin
      e_cmd = s_wd;
      busy_left = busy_cfg;
      if (s_wd[11:10] == 2'd2) e_data = phy_mem[s_wd[9:5]][s_wd[4:0]];
      else if (s_wd[11:10] == 2'd1) phy_mem[s_wd[9:5]][s_wd[4:0]] = e_data;
    end else if (!s_w && s_rg == 5'h18) begin
      if (busy_left > 0) begin pend_d = e_cmd | 16'h8000; busy_left--; end
      else pend_d = e_cmd & 16'h7fff;
    end else begin
      pend_d = e_data;
    end
    pend = 1'b1;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (s_rv && s_rdy) accept();
      if (sw_rsp_valid && s_rsp_rdy) sw_rsp_valid = 1'b0;
      if (s_rv && !s_rdy) begin
        // R10: stalled request must hold
        check("R10", "held valid", 32'(sw_req_valid), 32'd1);
        check("R10", "held fields", {sw_req_write, sw_req_reg, sw_req_wdata},
              {s_w, s_rg, s_wd});
      end
      if (pend && !sw_rsp_valid) begin
        sw_rsp_valid = 1'b1; sw_rsp_rdata = pend_d; sw_rsp_err = pend_e; pend = 1'b0;
      end
      sw_req_ready = (cyc % 3 != 1);
      s_rv = sw_req_valid; s_rdy = sw_req_ready; s_w = sw_req_write;
      s_dev = sw_req_dev; s_rg = sw_req_reg; s_wd = sw_req_wdata; s_rsp_rdy = sw_rsp_ready;
    end
  end

  task automatic push_acc(logic w, logic [4:0] rg, logic [15:0] d, logic chk, string t);
    acc_t e;
    e.w = w; e.rg = rg; e.d = d; e.chk = chk;
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic run_op(string tag, int op, int p, int r, logic [15:0] wd, logic [15:0] clr,
                        logic [15:0] st, int busy, int errat);
    logic [15:0] old, nw, ed, d0;
    logic [1:0]  s0;
    int rg, polls, nexp, est;
    logic rdy;
    rg = (op == 3) ? 'h16 : r;
    old = phy_mem[p][rg];
    nw = (old & ~clr) | st;
    polls = (busy >= MAXP) ? MAXP : busy + 1;
    exp_q.delete();
    tag_q.delete();
    if (op == 0 || op == 2) begin
      push_acc(1'b1, 5'h18, cmd_word(1, p, rg), 1'b1, "R2");
      for (int i = 0; i < polls; i++) push_acc(1'b0, 5'h18, '0, 1'b0, tag);
      if (busy < MAXP) push_acc(1'b0, 5'h19, '0, 1'b0, tag);
    end
    if (op == 1 || op == 3 || (op == 2 && busy < MAXP)) begin
      push_acc(1'b1, 5'h19, (op == 2) ? nw : wd, 1'b1, tag);
      push_acc(1'b1, 5'h18, cmd_word(0, p, rg), 1'b1, "R2");
      for (int i = 0; i < polls; i++) push_acc(1'b0, 5'h18, '0, 1'b0, tag);
    end
    nexp = exp_q.size();
    est = (errat >= 1 && errat <= nexp) ? 1 : (busy >= MAXP) ? 2 : 0;
    ed = (est == 0 && (op == 0 || op == 2)) ? old : 16'h0;
    busy_cfg = busy; err_at = errat; n_acc = 0;

    @(negedge clk);
    req_valid = 1'b1; req_op = 2'(op); req_phy = 5'(p); req_reg = 5'(r);
    req_wdata = wd; req_clr = clr; req_set = st;
    do begin rdy = req_ready; @(negedge clk); end while (!rdy);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    d0 = rsp_data; s0 = rsp_status;
    check("R9", "request blocked while busy", 32'(req_ready), 32'd0);
    @(negedge clk);
    @(negedge clk);
    check("R9", "response held", {15'd0, rsp_valid, rsp_data}, {15'd1, d0});
    check("R9", "status held", 32'(rsp_status), 32'(s0));
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9", "response withdrawn", 32'(rsp_valid), 32'd0);
    check(tag, "status", 32'(s0), 32'(est));
    check(tag, "data", 32'(d0), 32'(ed));
    check(tag, "missing accesses", 32'(exp_q.size()), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] keep;
    for (int p = 0; p < 32; p++)
      for (int r = 0; r < 32; r++)
        phy_mem[p][r] = 16'((p * 37 + r * 1021 + 'h1357) & 'hffff);
    phy_mem[15][0] = 16'h1940;
    repeat (3) @(negedge clk);
    // R11: idle state right after reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "req_ready", 32'(req_ready), 32'd1);
    check("R11", "rsp_valid", 32'(rsp_valid), 32'd0);
    check("R11", "sw_req_valid", 32'(sw_req_valid), 32'd0);

    run_op("R4", 1, 3, 4, 16'hBEEF, 0, 0, 2, 0);
    run_op("R3", 0, 3, 4, 0, 0, 0, 0, 0);
    run_op("R3", 0, 7, 9, 0, 0, 0, 5, 0);
    // R8: page 1 selects serdes on PHY 0x0F
    run_op("R8", 3, 15, 9, 16'h0001, 0, 0, 1, 0);
    check("R8", "page register", 32'(phy_mem[15][22]), 32'd1);
    check("R8", "req_reg ignored", 32'(phy_mem[15][9]), 32'((15 * 37 + 9 * 1021 + 'h1357) & 'hffff));
    run_op("R8", 0, 15, 22, 0, 0, 0, 0, 0);
    // R7: serdes power-up clears bit 11 of control register 0
    run_op("R7", 2, 15, 0, 0, 16'h0800, 16'h0000, 3, 0);
    check("R7", "written back", 32'(phy_mem[15][0]), 32'h1140);
    run_op("R7", 2, 6, 7, 0, 16'hff00, 16'h0005, 0, 0);
    // R5: clear on the last allowed poll, then timeout
    run_op("R5", 0, 2, 2, 0, 0, 0, MAXP - 1, 0);
    run_op("R5", 1, 2, 3, 16'h1234, 0, 0, MAXP, 0);
    keep = phy_mem[4][4];
    run_op("R7", 2, 4, 4, 0, 16'hffff, 16'h00ff, MAXP, 0);
    check("R7", "no write after read timeout", 32'(phy_mem[4][4]), 32'(keep));
    // R6: failing accesses at different points
    run_op("R6", 0, 5, 5, 0, 0, 0, 3, 2);
    keep = phy_mem[5][6];
    run_op("R6", 1, 5, 6, 16'hAAAA, 0, 0, 0, 1);
    check("R6", "write aborted", 32'(phy_mem[5][6]), 32'(keep));
    keep = phy_mem[6][6];
    run_op("R6", 2, 6, 6, 0, 16'h000f, 16'h0030, 0, 4);
    check("R6", "rmw aborted", 32'(phy_mem[6][6]), 32'(keep));

    repeat (4) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule